// File: doc/BRIEF.md
# Byte-wide SPI master/slave port

This block moves one byte at a time over a four-wire SPI link. Software sets it up through three byte-wide registers: a control register, a status register and a data register. In master mode the block generates the serial clock from a power-of-two divider of the system clock. A transfer begins when software writes the data register. In slave mode an external master supplies the serial clock and an active-low select. The byte that software wrote earlier is shifted out while the incoming byte is collected.

A single edge-select bit sets the clock idle level and both data edges in master mode. Data changes on the edge that leaves the idle level and is sampled on the edge that returns to it. In slave mode the port always changes data on the rising clock edge and samples on the falling edge. The edge-select bit and the divider field do not affect it. The external clock, the select and the serial input pass through a synchronizer in the system-clock domain. The external clock must therefore run at no more than a quarter of the system clock. When a byte completes, the received value is placed in the data register and a sticky completion flag is raised. The flag drives the interrupt output when the interrupt enable is set.

Top module: `spi_port`

## Requirements
- R1: Register map: address 0 is control (bit 7 edge select, bit 6 enable, bits 2:0 divider code), address 1 is status (bit 1 interrupt enable, bit 0 completion flag), address 2 is data. With edge select 0 in master mode, SCK idles low. Each bit is driven on SDO at a rising edge and SDI is sampled at the following falling edge. The most significant bit goes first.
- R2: With edge select 1 in master mode, SCK idles high. SDO changes on falling edges and SDI is sampled on rising edges, MSB first. Between transfers SCK rests at the level of the edge-select bit.
- R3: A divider code n from 0 to 6 selects master mode with an SCK period of 2^(n+1) system clocks. The completion flag is set exactly 16*2^n clock edges after the edge that registers the data write.
- R4: Divider code 7 selects slave mode. The port shifts out on the rising edge of the external SCK and samples SDI on its falling edge, MSB first. This holds whatever the edge-select bit is.
- R5: In slave mode, while the select is high, SDO output enable is low and SCK is ignored. A transfer cut short by the select rising is discarded: no flag is raised and the next transfer starts from its first bit.
- R6: After the eighth sampled bit, the received byte can be read at address 2 and status bit 0 is 1.
- R7: The completion flag stays 1 until software writes status with bit 0 at 0. Writing 1 to bit 0 leaves the flag unchanged.
- R8: The interrupt output is high exactly when the completion flag and the interrupt enable are both 1.
- R9: With enable at 0 (and out of reset) the port is idle: SCK and SDO output enables are low, a data write starts nothing, and no flag is raised.
- R10: A data write during a master transfer does not disturb that transfer's transmitted bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wdata | input | DW | Register write data |
| rdata | output | DW | Register read data for `addr` (combinational) |
| irq | output | 1 | Completion interrupt |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Serial clock output enable (master and enabled) |
| sck_i | input | 1 | Serial clock from an external master |
| ss_n_i | input | 1 | Active-low slave select from an external master |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |

## Verification
The bench sweeps every master divider code under both edge settings. For each run it counts clock edges up to the flag and records SCK edges and SDO bits. A divider off by one half period, or a swapped sample and drive edge, shows up as a wrong cycle count or a shifted received byte. Slave transfers run with both edge-select values and must give identical results. A slave that wrongly honoured the edge bit would return a garbled byte. An aborted slave transfer followed by clock pulses while deselected must leave the next full byte intact. A bit counter that was not reset, or that counted clocks while deselected, would misalign it. The bench also covers a write of 1 to the flag, a data write in the middle of a transfer, and a write while disabled. These catch a flag that toggles, a transfer that restarts, and a disabled clock generator that still runs.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
// Shared constants and register address codes for the SPI port.
package spi_port_pkg;
    // Width of the divider-code field in the control register.
    localparam int BAUD_W = 3;

    // Register addresses seen on the simple register bus.
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2
    } reg_addr_e;
endpackage

// File: rtl/spi_sckgen.sv
`timescale 1ns/1ps
// Master serial-clock generator.
// Counts system clocks per SCK half period (2^sel clocks) and emits a
// one-cycle lead tick (leaving idle level) and trail tick (returning to
// idle level). Runs for exactly 2*DW half periods after start.
// Assumes: sel is stable during a transfer; run_en low forces idle.
module spi_sckgen #(
    parameter int DW     = 8,
    parameter int BAUD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              start,
    input  logic [BAUD_W-1:0] sel,
    output logic              busy,
    output logic              phase,
    output logic              lead,
    output logic              trail
);
    localparam int CNT_W = (1 << BAUD_W) - 2;
    localparam int HC_W  = $clog2(2 * DW);
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(2 * DW - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [HC_W-1:0]  half_q;
    logic [CNT_W-1:0] lim;
    logic             tick;

    // Terminal count of the half-period counter.
    assign lim  = CNT_W'((1 << sel) - 1);
    assign tick = busy && (cnt_q == lim);
    assign lead  = tick && !phase;
    assign trail = tick && phase;

    // Half-period counting, SCK phase and transfer length.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            busy   <= 1'b0;
            phase  <= 1'b0;
            cnt_q  <= '0;
            half_q <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            phase  <= 1'b0;
            cnt_q  <= '0;
            half_q <= '0;
        end else if (busy) begin
            if (tick) begin
                cnt_q <= '0;
                phase <= ~phase;
                if (half_q == HC_LAST) begin
                    half_q <= '0;
                    busy   <= 1'b0;
                end else begin
                    half_q <= half_q + 1'b1;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R3: the last half period ends the transfer with SCK back at idle.
    assert_stop_at_last_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && tick && half_q == HC_LAST) |=> (!busy && !phase));
endmodule

// File: rtl/spi_slv_sync.sv
`timescale 1ns/1ps
// Slave-side input synchronizer and SCK edge detector.
// Brings external SCK, select and SDI into the system-clock domain through
// STAGES flops each, and flags rising and falling SCK edges for one cycle.
// Assumes: external SCK runs at no more than a quarter of clk.
module spi_slv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic ss_n_i,
    input  logic sdi_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic sel_act,
    output logic sdi_sync
);
    logic [STAGES-1:0] sck_q;
    logic [STAGES-1:0] ss_q;
    logic [STAGES-1:0] sdi_q;
    logic              sck_last;

    // Synchronizer chains plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q    <= '0;
            ss_q     <= '1;
            sdi_q    <= '0;
            sck_last <= 1'b0;
        end else begin
            sck_q    <= {sck_q[STAGES-2:0], sck_i};
            ss_q     <= {ss_q[STAGES-2:0], ss_n_i};
            sdi_q    <= {sdi_q[STAGES-2:0], sdi_i};
            sck_last <= sck_q[STAGES-1];
        end
    end

    assign sck_rise = sck_q[STAGES-1] && !sck_last;
    assign sck_fall = !sck_q[STAGES-1] && sck_last;
    assign sel_act  = !ss_q[STAGES-1];
    assign sdi_sync = sdi_q[STAGES-1];
endmodule

// File: rtl/spi_shift.sv
`timescale 1ns/1ps
// Byte shift engine shared by master and slave modes.
// Lead pulses move the next transmit bit (MSB first) onto sdo; trail pulses
// sample sdi. done pulses on the DW-th sample with rx_word holding the byte.
// Assumes: clear holds the bit count at zero; load may coincide with clear.
module spi_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic [DW-1:0] load_byte,
    input  logic          lead,
    input  logic          trail,
    input  logic          sdi,
    output logic          sdo,
    output logic          done,
    output logic [DW-1:0] rx_word
);
    localparam int BC_W = $clog2(DW);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(DW - 1);

    logic [DW-1:0]   tx_sr;
    logic [DW-2:0]   rx_sr;
    logic [BC_W-1:0] bit_q;

    assign rx_word = {rx_sr, sdi};
    assign done    = trail && !clear && (bit_q == BC_LAST);

    // Transmit shifting, receive shifting and bit counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
            rx_sr <= '0;
            bit_q <= '0;
            sdo   <= 1'b0;
        end else begin
            if (load) begin
                tx_sr <= load_byte;
            end else if (lead && !clear) begin
                sdo   <= tx_sr[DW-1];
                tx_sr <= tx_sr << 1;
            end
            if (clear) begin
                bit_q <= '0;
            end else if (trail) begin
                rx_sr <= rx_word[DW-2:0];
                bit_q <= (bit_q == BC_LAST) ? '0 : bit_q + 1'b1;
            end
        end
    end

    // R6: a completed byte leaves the counter ready for the next first bit.
    assert_count_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (bit_q == '0));
endmodule

// File: rtl/spi_port.sv
`timescale 1ns/1ps
// SPI master/slave port with control, status and data registers.
// Master mode (divider code 0..6) drives SCK from spi_sckgen; slave mode
// (code 7) follows external SCK and select through spi_slv_sync.
// Assumes: DW >= 8; configuration is not changed during a transfer.
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq,
    output logic          sck_o,
    output logic          sck_oe,
    input  logic          sck_i,
    input  logic          ss_n_i,
    input  logic          sdi_i,
    output logic          sdo_o,
    output logic          sdo_oe
);
    localparam logic [BAUD_W-1:0] SLAVE_CODE = '1;
    localparam int EDGE_BIT = 7;
    localparam int EN_BIT   = 6;

    logic [DW-1:0] ctrl_q;
    logic          ie_q;
    logic          flag_q;
    logic [DW-1:0] rx_buf_q;
    logic [DW-1:0] tx_hold_q;

    logic          edge_sel, enable, is_slave, master_on, slave_on;
    logic          wr_ctrl, wr_stat, wr_data, start_req;
    logic          busy, phase, m_lead, m_trail;
    logic          s_rise, s_fall, ss_act, s_sdi;
    logic          sh_clear, sh_load, sh_lead, sh_trail, sh_sdi, sh_done;
    logic [DW-1:0] sh_load_byte, sh_rx_word;

    assign edge_sel  = ctrl_q[EDGE_BIT];
    assign enable    = ctrl_q[EN_BIT];
    assign is_slave  = (ctrl_q[BAUD_W-1:0] == SLAVE_CODE);
    assign master_on = enable && !is_slave;
    assign slave_on  = enable && is_slave;

    assign wr_ctrl   = wr_en && (addr == REG_CTRL);
    assign wr_stat   = wr_en && (addr == REG_STAT);
    assign wr_data   = wr_en && (addr == REG_DATA);
    assign start_req = wr_data && master_on;

    spi_sckgen #(.DW(DW), .BAUD_W(BAUD_W)) u_sckgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (master_on),
        .start  (start_req),
        .sel    (ctrl_q[BAUD_W-1:0]),
        .busy   (busy),
        .phase  (phase),
        .lead   (m_lead),
        .trail  (m_trail)
    );

    spi_slv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (sck_i),
        .ss_n_i   (ss_n_i),
        .sdi_i    (sdi_i),
        .sck_rise (s_rise),
        .sck_fall (s_fall),
        .sel_act  (ss_act),
        .sdi_sync (s_sdi)
    );

    // Route shifter controls from the active mode's clock source.
    always_comb begin
        sh_clear     = !enable || (is_slave && !ss_act);
        sh_load      = master_on ? (start_req && !busy) : (is_slave && !ss_act);
        sh_load_byte = master_on ? wdata : tx_hold_q;
        sh_lead      = master_on ? m_lead  : s_rise;
        sh_trail     = master_on ? m_trail : s_fall;
        sh_sdi       = master_on ? sdi_i   : s_sdi;
    end

    spi_shift #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (sh_clear),
        .load      (sh_load),
        .load_byte (sh_load_byte),
        .lead      (sh_lead),
        .trail     (sh_trail),
        .sdi       (sh_sdi),
        .sdo       (sdo_o),
        .done      (sh_done),
        .rx_word   (sh_rx_word)
    );

    // Control register and slave transmit holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            tx_hold_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata;
            if (wr_data) tx_hold_q <= wdata;
        end
    end

    // Status register: interrupt enable and sticky completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (wr_stat) ie_q <= wdata[1];
            if (sh_done) flag_q <= 1'b1;
            else if (wr_stat && !wdata[0]) flag_q <= 1'b0;
        end
    end

    // Receive buffer captures the finished byte.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_buf_q <= '0;
        else if (sh_done) rx_buf_q <= sh_rx_word;
    end

    // Register read multiplexer.
    always_comb begin
        case (addr)
            REG_CTRL: rdata = ctrl_q;
            REG_STAT: rdata = {{(DW-2){1'b0}}, ie_q, flag_q};
            REG_DATA: rdata = rx_buf_q;
            default:  rdata = '0;
        endcase
    end

    assign irq    = flag_q && ie_q;
    assign sck_o  = edge_sel ^ phase;
    assign sck_oe = master_on;
    assign sdo_oe = master_on || (slave_on && ss_act);

    // R2: a master with no transfer in flight rests SCK at the edge-select level.
    assert_sck_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (master_on && !busy) |-> (sck_o == edge_sel));

    // R7: only a status write with bit 0 low can clear the flag.
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_stat && !wdata[0])) |=> flag_q);

    // R9: a disabled port never keeps the clock generator running.
    assert_off_no_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !busy);

    // R4: in slave mode the internal clock generator stays stopped.
    assert_slave_no_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        slave_on |=> !busy);
endmodule

// File: tb/tb_spi_port.sv
`timescale 1ns/1ps
module tb_spi_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq, sck_o, sck_oe, sdo_o, sdo_oe;
    logic       sck_i = 1'b0;
    logic       ss_n_i = 1'b1;
    logic       sdi_i = 1'b0;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    spi_port dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
        .ss_n_i(ss_n_i), .sdi_i(sdi_i), .sdo_o(sdo_o), .sdo_oe(sdo_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // Master transfer with the bench acting as the external slave.
    task automatic master_run(input int n, input bit ces, input bit ie,
                              input logic [7:0] tx, input logic [7:0] slv, input bit mid);
        logic [7:0] txcap = 8'd0;
        logic [7:0] rb;
        logic       prev;
        int         leads = 0;
        int         trails = 0;
        int         done_k = -1;
        int         mid_k = 8 << n;
        wr(2'd0, {ces, 1'b1, 3'b000, n[2:0]});
        wr(2'd1, {6'd0, ie, 1'b0});
        wr(2'd2, tx);
        addr = 2'd1;
        prev = ces;
        for (int k = 1; k <= 2500; k++) begin
            @(posedge clk);
            #1;
            if (mid && k == mid_k + 1) begin
                wr_en = 1'b0; addr = 2'd1; #1;
            end
            if (sck_o != prev) begin
                if (sck_o != ces) begin
                    if (leads < 8) sdi_i = slv[7 - leads];
                    leads++;
                end else begin
                    if (trails < 8) txcap[7 - trails] = sdo_o;
                    trails++;
                end
                prev = sck_o;
            end
            if (addr == 2'd1 && rdata[0]) begin
                done_k = k;
                break;
            end
            if (mid && k == mid_k) begin
                wr_en = 1'b1; addr = 2'd2; wdata = ~tx;
            end
        end
        chk(done_k == (16 << n), "R3 cycles to flag", done_k, 16 << n);
        chk(leads == 8 && trails == 8, "R3 edge count", leads * 16 + trails, 8 * 16 + 8);
        if (mid) chk(txcap == tx, "R10 tx bits", txcap, tx);
        else if (ces) chk(txcap == tx, "R2 tx bits", txcap, tx);
        else chk(txcap == tx, "R1 tx bits", txcap, tx);
        @(negedge clk);
        chk(sck_o == ces, "R2 idle level", sck_o, ces);
        chk(irq == ie, "R8 irq", irq, ie);
        rd(2'd2, rb);
        chk(rb == slv, "R6 rx byte", rb, slv);
    endtask

    // Slave transfer with the bench acting as external master.
    task automatic slave_run(input bit ces, input logic [7:0] stx,
                             input logic [7:0] mtx, input int nbits);
        logic [7:0] cap = 8'd0;
        logic [7:0] rb;
        wr(2'd0, {ces, 1'b1, 3'b000, 3'b111});
        wr(2'd1, 8'h02);
        wr(2'd2, stx);
        repeat (4) @(negedge clk);
        chk(sdo_oe == 1'b0, "R5 oe released", sdo_oe, 0);
        ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
        chk(sdo_oe == 1'b1, "R4 oe driven", sdo_oe, 1);
        for (int i = 0; i < nbits; i++) begin
            sdi_i = mtx[7 - i];
            sck_i = 1'b1;
            repeat (6) @(negedge clk);
            cap[7 - i] = sdo_o;
            sck_i = 1'b0;
            repeat (6) @(negedge clk);
        end
        ss_n_i = 1'b1;
        repeat (6) @(negedge clk);
        chk(sdo_oe == 1'b0, "R5 oe after deselect", sdo_oe, 0);
        rd(2'd1, rb);
        if (nbits == 8) begin
            chk(cap == stx, "R4 slave tx bits", cap, stx);
            chk(rb[0] == 1'b1, "R6 slave flag", rb[0], 1);
            rd(2'd2, rb);
            chk(rb == mtx, "R4 slave rx byte", rb, mtx);
        end else begin
            chk(rb[0] == 1'b0, "R5 aborted no flag", rb[0], 0);
        end
    endtask

    initial begin
        logic [7:0] rb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: disabled and quiet (R9)
        chk(sck_oe == 1'b0 && sdo_oe == 1'b0 && irq == 1'b0, "R9 reset outputs",
            {sck_oe, sdo_oe, irq}, 0);
        rd(2'd0, rb); chk(rb == 8'h00, "R9 reset ctrl", rb, 0);
        rd(2'd1, rb); chk(rb == 8'h00, "R9 reset status", rb, 0);

        // R1 R2 R3 R6 R8: sweep every divider and both edges
        for (int n = 0; n < 7; n++) begin
            for (int c = 0; c < 2; c++) begin
                master_run(n, c[0], 1'b1, 8'(8'hA5 ^ (n * 37 + c * 91)),
                           8'(8'h3C + n * 29 + c * 113), 1'b0);
            end
        end

        // R10: write during a transfer is ignored
        master_run(2, 1'b0, 1'b1, 8'hC3, 8'h5A, 1'b1);

        // R7: writing 1 keeps the flag, writing 0 clears it
        wr(2'd1, 8'h03);
        rd(2'd1, rb); chk(rb[0] == 1'b1, "R7 write one keeps flag", rb[0], 1);
        wr(2'd1, 8'h02);
        rd(2'd1, rb); chk(rb[0] == 1'b0, "R7 write zero clears", rb[0], 0);
        chk(irq == 1'b0, "R8 irq low after clear", irq, 0);

        // R8: flag set but interrupt disabled
        master_run(1, 1'b1, 1'b0, 8'h81, 8'h7E, 1'b0);
        rd(2'd1, rb); chk(rb[0] == 1'b1, "R8 flag without ie", rb[0], 1);

        // R9: disabled port ignores data writes
        wr(2'd0, 8'h80);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h55);
        addr = 2'd1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (sck_o != 1'b1) begin
                chk(1'b0, "R9 sck moved while off", sck_o, 1);
                break;
            end
        end
        rd(2'd1, rb);
        chk(rb[0] == 1'b0, "R9 no flag while off", rb[0], 0);
        chk(sck_oe == 1'b0 && sdo_oe == 1'b0, "R9 oe low while off", {sck_oe, sdo_oe}, 0);

        // R4: slave ignores edge select and divider semantics
        slave_run(1'b0, 8'h96, 8'h2D, 8);
        slave_run(1'b1, 8'h4B, 8'hD2, 8);

        // R5: abort after four bits, clock pulses while deselected, then full byte
        slave_run(1'b0, 8'hE1, 8'hF0, 4);
        for (int i = 0; i < 3; i++) begin
            sdi_i = 1'b1; sck_i = 1'b1;
            repeat (6) @(negedge clk);
            sck_i = 1'b0;
            repeat (6) @(negedge clk);
        end
        rd(2'd1, rb); chk(rb[0] == 1'b0, "R5 sck ignored deselected", rb[0], 0);
        chk(sdo_oe == 1'b0, "R5 oe low deselected", sdo_oe, 0);
        slave_run(1'b0, 8'h3A, 8'h6C, 8);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule